// File: doc/BRIEF.md
# Snooping Write-Back Line Coherence Controller

This block keeps a small direct-mapped write-back cache coherent with its peers on a shared snooping bus. Each line is held in one of three states: Invalid, Shared (clean, read-only) or Exclusive (dirty, writable). CPU reads and writes that hit are answered at once with no bus traffic. Misses, upgrades from Shared to Exclusive, and dirty victims go out on the bus as read-miss, write-miss or write-back transactions. A dirty victim is always written back first, before the new miss goes out.

In parallel the block watches miss transactions placed by other caches. When a peer asks for a line that this cache holds dirty, the block intercepts the request in the same cycle. It raises an intercept flag that tells memory to abort its response and drives the dirty word onto the snoop data lines. It then downgrades or invalidates its own copy. Bus ownership is modelled as a request/grant pair, and completion of an own transaction is signalled by a done strobe that carries the fill data.

Top module: `snoop_wb_coh_ctrl`

## Requirements
- R1: After reset every line is Invalid, bus_req is low, and no snoop to any address raises snp_intercept.
- R2: A CPU read whose line is not present (Invalid or other tag, not dirty) issues a read miss (bus_cmd_o = 1) for cpu_addr, returns the bus_rdata delivered with bus_done, and leaves the line Shared.
- R3: A CPU write to a line that is Invalid, holds another clean tag, or holds the same tag in Shared issues a write miss (bus_cmd_o = 2) for cpu_addr and leaves the line Exclusive holding cpu_wdata.
- R4: A read hit in Shared or Exclusive, or a write hit in Exclusive, raises cpu_ready in the request cycle with no bus transaction; a read hit returns the stored word.
- R5: A snooped read miss (snp_cmd = 1) to a line held Exclusive with the same tag raises snp_intercept in that cycle with the line's word on snp_data, and the line becomes Shared.
- R6: A snooped write miss (snp_cmd = 2) to a line held Exclusive with the same tag raises snp_intercept with the line's word on snp_data, and the line becomes Invalid.
- R7: A snooped write miss to a line held Shared with the same tag invalidates it without raising snp_intercept.
- R8: A snooped read miss to a Shared line, or any snoop whose tag differs from the stored tag or whose line is Invalid, changes nothing and does not intercept.
- R9: A CPU read or write that maps onto an Exclusive line with a different tag first issues a write-back (bus_cmd_o = 3) carrying the old tag's address (old tag above, index in the low 2 address bits) and the dirty word, then the read or write miss.
- R10: A missing CPU request holds cpu_ready low until its last bus transaction completes; bus_req stays high until bus_gnt; cpu_ready stays low in any cycle with snp_valid high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | CPU access request, held until cpu_ready |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address; low IDX_W bits select the line |
| cpu_wdata | input | DATA_W | Write data |
| cpu_ready | output | 1 | Access completes this cycle |
| cpu_rdata | output | DATA_W | Read data, valid with cpu_ready |
| bus_req | output | 1 | Request for bus ownership |
| bus_gnt | input | 1 | Bus ownership granted |
| bus_cmd_o | output | 2 | Own transaction: 0 none, 1 read miss, 2 write miss, 3 write-back |
| bus_addr_o | output | ADDR_W | Address of own transaction |
| bus_wdata_o | output | DATA_W | Write-back data |
| bus_done | input | 1 | Own transaction complete |
| bus_rdata | input | DATA_W | Fill data delivered with bus_done |
| snp_valid | input | 1 | Peer miss visible on the bus |
| snp_cmd | input | 2 | Peer miss kind: 1 read miss, 2 write miss |
| snp_addr | input | ADDR_W | Peer miss address |
| snp_intercept | output | 1 | Dirty copy supplied here; memory must abort |
| snp_data | output | DATA_W | Dirty word supplied on intercept |

## Verification
A wrong line state stays hidden until the next access to that index. A line wrongly left Exclusive shows up as an intercept on a later peer miss, or as a missing write miss. A line wrongly dropped to Invalid shows up as an extra read miss on the next CPU access. A lost dirty word shows up as a write-back or snoop data mismatch, or as a wrong fill returned once the bench memory has been refreshed by a write-back. The bench therefore compares every bus transaction and every snoop reply against a reference model of each line and of memory. It revisits each index often through a small tag pool.

// File: rtl/coh_pkg.sv
// Shared types for the snooping coherence controller.
package coh_pkg;
    typedef enum logic [1:0] {
        LN_INV = 2'd0,
        LN_SHR = 2'd1,
        LN_EXC = 2'd2
    } line_st_e;

    typedef enum logic [1:0] {
        BC_NONE   = 2'd0,
        BC_RDMISS = 2'd1,
        BC_WRMISS = 2'd2,
        BC_WBACK  = 2'd3
    } bus_cmd_e;

    typedef enum logic [1:0] {
        FS_IDLE = 2'd0,
        FS_ARB  = 2'd1,
        FS_XFER = 2'd2
    } fsm_e;
endpackage

// File: rtl/coh_line_store.sv
// Per-line state, tag and data registers with a CPU port and a snoop port.
// Assumes the snoop port and the CPU port never update one line in the same
// cycle; the snoop port wins if they do.
module coh_line_store
    import coh_pkg::*;
#(
    parameter int IDX_W  = 2,
    parameter int TAG_W  = 6,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  cpu_idx,
    input  logic              cpu_we,
    input  line_st_e          cpu_st_new,
    input  logic [TAG_W-1:0]  cpu_tag_new,
    input  logic [DATA_W-1:0] cpu_data_new,
    output line_st_e          cpu_st,
    output logic [TAG_W-1:0]  cpu_tag,
    output logic [DATA_W-1:0] cpu_data,
    input  logic [IDX_W-1:0]  snp_idx,
    input  logic              snp_we,
    input  line_st_e          snp_st_new,
    output line_st_e          snp_st,
    output logic [TAG_W-1:0]  snp_tag,
    output logic [DATA_W-1:0] snp_data
);
    localparam int LINES = 1 << IDX_W;

    line_st_e          st_v   [LINES];
    logic [TAG_W-1:0]  tag_v  [LINES];
    logic [DATA_W-1:0] data_v [LINES];

    for (genvar i = 0; i < LINES; i++) begin : g_line
        line_st_e          st_q;
        logic [TAG_W-1:0]  tag_q;
        logic [DATA_W-1:0] data_q;

        // Hold one line; snoop downgrades take priority over CPU fills.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                st_q   <= LN_INV;
                tag_q  <= '0;
                data_q <= '0;
            end else if (snp_we && snp_idx == IDX_W'(i)) begin
                st_q <= snp_st_new;
            end else if (cpu_we && cpu_idx == IDX_W'(i)) begin
                st_q   <= cpu_st_new;
                tag_q  <= cpu_tag_new;
                data_q <= cpu_data_new;
            end
        end

        assign st_v[i]   = st_q;
        assign tag_v[i]  = tag_q;
        assign data_v[i] = data_q;
    end

    assign cpu_st   = st_v[cpu_idx];
    assign cpu_tag  = tag_v[cpu_idx];
    assign cpu_data = data_v[cpu_idx];
    assign snp_st   = st_v[snp_idx];
    assign snp_tag  = tag_v[snp_idx];
    assign snp_data = data_v[snp_idx];
endmodule

// File: rtl/coh_snoop_unit.sv
// Decodes a peer miss against the addressed line: decides intercept and the
// state the line moves to. Purely combinational.
module coh_snoop_unit
    import coh_pkg::*;
#(
    parameter int TAG_W = 6
) (
    input  logic             snp_valid,
    input  bus_cmd_e         snp_cmd,
    input  logic [TAG_W-1:0] snp_tag,
    input  line_st_e         line_st,
    input  logic [TAG_W-1:0] line_tag,
    output logic             intercept,
    output logic             upd_we,
    output line_st_e         upd_st
);
    logic match;

    // Classify the snoop and pick the downgrade.
    always_comb begin
        match     = snp_valid && (line_st != LN_INV) && (line_tag == snp_tag);
        intercept = 1'b0;
        upd_we    = 1'b0;
        upd_st    = line_st;
        if (match && snp_cmd == BC_RDMISS && line_st == LN_EXC) begin
            intercept = 1'b1;
            upd_we    = 1'b1;
            upd_st    = LN_SHR;
        end else if (match && snp_cmd == BC_WRMISS) begin
            intercept = (line_st == LN_EXC);
            upd_we    = 1'b1;
            upd_st    = LN_INV;
        end
    end
endmodule

// File: rtl/coh_miss_fsm.sv
// CPU-side sequencer: answers hits, arbitrates for the bus on misses,
// writes back a dirty victim before the miss, and fills the line.
// Assumes cpu_req and its fields are held until cpu_ready, and that no
// snoop arrives while this cache owns the bus.
module coh_miss_fsm
    import coh_pkg::*;
#(
    parameter int TAG_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_req,
    input  logic             cpu_we,
    input  logic [TAG_W-1:0] cpu_tag,
    input  line_st_e         line_st,
    input  logic [TAG_W-1:0] line_tag,
    input  logic             snp_valid,
    input  logic             bus_gnt,
    input  logic             bus_done,
    output logic             cpu_ready,
    output logic             bus_req,
    output bus_cmd_e         bus_cmd,
    output logic             line_we,
    output line_st_e         line_st_new,
    output logic             fill_sel
);
    fsm_e     st_q, st_d;
    bus_cmd_e cmd_q, cmd_d;
    logic     tag_eq, hit;

    // Next-state and output decode.
    always_comb begin
        tag_eq      = (line_tag == cpu_tag);
        hit         = (line_st != LN_INV) && tag_eq && (!cpu_we || line_st == LN_EXC);
        st_d        = st_q;
        cmd_d       = cmd_q;
        cpu_ready   = 1'b0;
        bus_req     = 1'b0;
        bus_cmd     = BC_NONE;
        line_we     = 1'b0;
        line_st_new = line_st;
        fill_sel    = 1'b0;
        case (st_q)
            FS_IDLE: begin
                if (cpu_req && !snp_valid) begin
                    if (hit) begin
                        cpu_ready = 1'b1;
                        if (cpu_we) begin
                            line_we     = 1'b1;
                            line_st_new = LN_EXC;
                        end
                    end else begin
                        st_d = FS_ARB;
                    end
                end
            end
            FS_ARB: begin
                bus_req = 1'b1;
                if (bus_gnt) begin
                    st_d = FS_XFER;
                    if (line_st == LN_EXC && !tag_eq) cmd_d = BC_WBACK;
                    else if (cpu_we)                  cmd_d = BC_WRMISS;
                    else                              cmd_d = BC_RDMISS;
                end
            end
            FS_XFER: begin
                bus_cmd = cmd_q;
                if (bus_done) begin
                    line_we = 1'b1;
                    if (cmd_q == BC_WBACK) begin
                        line_st_new = LN_INV;
                        st_d        = FS_ARB;
                    end else begin
                        cpu_ready   = 1'b1;
                        line_st_new = (cmd_q == BC_RDMISS) ? LN_SHR : LN_EXC;
                        fill_sel    = (cmd_q == BC_RDMISS);
                        st_d        = FS_IDLE;
                    end
                end
            end
            default: st_d = FS_IDLE;
        endcase
    end

    // Sequencer registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= FS_IDLE;
            cmd_q <= BC_NONE;
        end else begin
            st_q  <= st_d;
            cmd_q <= cmd_d;
        end
    end
endmodule

// File: rtl/snoop_wb_coh_ctrl.sv
// Top: three-state write-back coherence controller for a small
// direct-mapped cache on a snooping bus. Address = {tag, index}.
module snoop_wb_coh_ctrl
    import coh_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int IDX_W  = 2,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ready,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic [1:0]        bus_cmd_o,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic [DATA_W-1:0] bus_wdata_o,
    input  logic              bus_done,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              snp_valid,
    input  logic [1:0]        snp_cmd,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              snp_intercept,
    output logic [DATA_W-1:0] snp_data
);
    localparam int TAG_W = ADDR_W - IDX_W;

    logic [IDX_W-1:0]  cpu_idx, snp_idx;
    logic [TAG_W-1:0]  cpu_tag, snp_tag, line_tag, snp_line_tag;
    line_st_e          line_st, snp_line_st, line_st_new, snp_st_new;
    logic [DATA_W-1:0] line_data, line_data_new;
    logic              line_we, snp_we, fill_sel;
    bus_cmd_e          cmd;

    assign cpu_idx = cpu_addr[IDX_W-1:0];
    assign cpu_tag = cpu_addr[ADDR_W-1:IDX_W];
    assign snp_idx = snp_addr[IDX_W-1:0];
    assign snp_tag = snp_addr[ADDR_W-1:IDX_W];

    coh_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
        .clk          (clk),
        .rst_n        (rst_n),
        .cpu_idx      (cpu_idx),
        .cpu_we       (line_we),
        .cpu_st_new   (line_st_new),
        .cpu_tag_new  (cpu_tag),
        .cpu_data_new (line_data_new),
        .cpu_st       (line_st),
        .cpu_tag      (line_tag),
        .cpu_data     (line_data),
        .snp_idx      (snp_idx),
        .snp_we       (snp_we),
        .snp_st_new   (snp_st_new),
        .snp_st       (snp_line_st),
        .snp_tag      (snp_line_tag),
        .snp_data     (snp_data)
    );

    coh_snoop_unit #(.TAG_W(TAG_W)) u_snoop (
        .snp_valid (snp_valid),
        .snp_cmd   (bus_cmd_e'(snp_cmd)),
        .snp_tag   (snp_tag),
        .line_st   (snp_line_st),
        .line_tag  (snp_line_tag),
        .intercept (snp_intercept),
        .upd_we    (snp_we),
        .upd_st    (snp_st_new)
    );

    coh_miss_fsm #(.TAG_W(TAG_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .cpu_req     (cpu_req),
        .cpu_we      (cpu_we),
        .cpu_tag     (cpu_tag),
        .line_st     (line_st),
        .line_tag    (line_tag),
        .snp_valid   (snp_valid),
        .bus_gnt     (bus_gnt),
        .bus_done    (bus_done),
        .cpu_ready   (cpu_ready),
        .bus_req     (bus_req),
        .bus_cmd     (cmd),
        .line_we     (line_we),
        .line_st_new (line_st_new),
        .fill_sel    (fill_sel)
    );

    assign line_data_new = fill_sel ? bus_rdata : cpu_wdata;
    assign cpu_rdata     = fill_sel ? bus_rdata : line_data;
    assign bus_cmd_o     = cmd;
    assign bus_addr_o    = (cmd == BC_WBACK) ? {line_tag, cpu_idx} : cpu_addr;
    assign bus_wdata_o   = line_data;
endmodule

// File: rtl/coh_ctrl_checker.sv
// Temporal checks on the controller's ports, bound to the top module.
module coh_ctrl_checker #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_ready,
    input logic              bus_req,
    input logic              bus_gnt,
    input logic [1:0]        bus_cmd_o,
    input logic              bus_done,
    input logic              snp_valid,
    input logic [1:0]        snp_cmd,
    input logic [ADDR_W-1:0] snp_addr,
    input logic              snp_intercept
);
    // R4: a completing access never coincides with arbitration or a write-back.
    p_ready_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |-> (!bus_req && bus_cmd_o != 2'd3));

    // R10: a bus request is held until granted.
    p_req_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_gnt) |=> bus_req);

    // R10: no completion while a peer miss is on the bus.
    p_snoop_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
        snp_valid |-> !cpu_ready);

    // R9: a finished write-back returns to arbitration for the miss.
    p_wb_then_miss_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_done && bus_cmd_o == 2'd3) |=> bus_req);

    // R2: requesting and transferring are never both shown.
    p_req_or_xfer_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_req && bus_cmd_o != 2'd0));

    // R5: after an intercepted read miss the line is no longer dirty.
    p_no_reflush_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && snp_intercept && snp_cmd == 2'd1) |=>
        !(snp_valid && snp_intercept && snp_addr == $past(snp_addr)));

    // R6: after an intercepted write miss the line holds nothing to supply.
    p_no_reflush_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && snp_intercept && snp_cmd == 2'd2) |=>
        !(snp_valid && snp_intercept && snp_addr == $past(snp_addr)));
endmodule

bind snoop_wb_coh_ctrl coh_ctrl_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cpu_ready     (cpu_ready),
    .bus_req       (bus_req),
    .bus_gnt       (bus_gnt),
    .bus_cmd_o     (bus_cmd_o),
    .bus_done      (bus_done),
    .snp_valid     (snp_valid),
    .snp_cmd       (snp_cmd),
    .snp_addr      (snp_addr),
    .snp_intercept (snp_intercept)
);

// File: tb/snoop_wb_coh_ctrl_tb.sv
// Bench: reference line/memory model, a bus responder with random latency,
// directed corner cases, then seeded random traffic.
module snoop_wb_coh_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int Q          = CLK_PERIOD / 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_req = 1'b0, cpu_we = 1'b0;
    logic [7:0] cpu_addr = '0, cpu_wdata = '0;
    logic       cpu_ready;
    logic [7:0] cpu_rdata;
    logic       bus_req, bus_gnt, bus_done;
    logic [1:0] bus_cmd_o;
    logic [7:0] bus_addr_o, bus_wdata_o, bus_rdata;
    logic       snp_valid = 1'b0;
    logic [1:0] snp_cmd = '0;
    logic [7:0] snp_addr = '0;
    logic       snp_intercept;
    logic [7:0] snp_data;

    int checks = 0, fails = 0;

    logic [7:0] mem   [256];
    int         m_st  [4];
    logic [5:0] m_tag [4];
    logic [7:0] m_dat [4];

    int         lg_n;
    logic [1:0] lg_cmd  [4];
    logic [7:0] lg_addr [4];
    logic [7:0] lg_dat  [4];

    always #(CLK_PERIOD/2) clk = ~clk;

    snoop_wb_coh_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready),
        .cpu_rdata(cpu_rdata), .bus_req(bus_req), .bus_gnt(bus_gnt),
        .bus_cmd_o(bus_cmd_o), .bus_addr_o(bus_addr_o), .bus_wdata_o(bus_wdata_o),
        .bus_done(bus_done), .bus_rdata(bus_rdata), .snp_valid(snp_valid),
        .snp_cmd(snp_cmd), .snp_addr(snp_addr), .snp_intercept(snp_intercept),
        .snp_data(snp_data)
    );

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Watchdog: a hung run is a failed check.
    initial begin
        #(CLK_PERIOD * 150000);
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    // Bus responder: grant after random delay, log transaction, complete it.
    initial begin
        int ph = 0, dly = 0;
        logic [1:0] c_cmd;
        logic [7:0] c_addr, c_wd;
        bus_gnt = 1'b0; bus_done = 1'b0; bus_rdata = '0;
        forever begin
            @(negedge clk);
            case (ph)
                0: if (rst_n && bus_req) begin
                       if (dly == 0) begin bus_gnt = 1'b1; ph = 1; end
                       else dly--;
                   end
                1: begin
                       bus_gnt = 1'b0;
                       c_cmd = bus_cmd_o; c_addr = bus_addr_o; c_wd = bus_wdata_o;
                       if (lg_n < 4) begin
                           lg_cmd[lg_n] = c_cmd; lg_addr[lg_n] = c_addr; lg_dat[lg_n] = c_wd;
                       end
                       lg_n++;
                       dly = $urandom % 3;
                       ph = 2;
                   end
                2: if (dly == 0) begin
                       bus_done = 1'b1;
                       if (c_cmd == 2'd3) mem[c_addr] = c_wd;
                       else bus_rdata = mem[c_addr];
                       ph = 3;
                   end else dly--;
                default: begin
                       bus_done = 1'b0;
                       dly = $urandom % 3;
                       ph = 0;
                   end
            endcase
        end
    end

    // One CPU access, checked against the model (R2, R3, R4, R9, R10).
    task automatic cpu_op(input bit we, input logic [7:0] addr, input logic [7:0] wd);
        int idx = int'(addr[1:0]);
        logic [5:0] tg = addr[7:2];
        int en = 0;
        logic [1:0] e_cmd [2];
        logic [7:0] e_addr [2];
        logic [7:0] e_dat [2];
        logic [7:0] e_rd;
        logic [7:0] got;
        bit hit = (m_st[idx] != 0) && (m_tag[idx] == tg) && (!we || m_st[idx] == 2);
        string rq;
        if (hit) begin
            rq = "R4";
            e_rd = m_dat[idx];
            if (we) m_dat[idx] = wd;
        end else begin
            rq = we ? "R3" : "R2";
            if (m_st[idx] == 2 && m_tag[idx] != tg) begin
                rq = "R9";
                e_cmd[0] = 2'd3; e_addr[0] = {m_tag[idx], addr[1:0]}; e_dat[0] = m_dat[idx];
                en = 1;
            end
            e_cmd[en] = we ? 2'd2 : 2'd1; e_addr[en] = addr; e_dat[en] = 8'h00;
            en++;
            e_rd = (m_st[idx] == 2 && m_tag[idx] != tg && {m_tag[idx], addr[1:0]} == addr)
                   ? m_dat[idx] : mem[addr];
            m_st[idx] = we ? 2 : 1;
            m_tag[idx] = tg;
            m_dat[idx] = we ? wd : e_rd;
        end
        lg_n = 0;
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = addr; cpu_wdata = wd;
        forever begin
            #Q;
            if (cpu_ready) break;
            @(negedge clk);
        end
        got = cpu_rdata;
        @(negedge clk);
        cpu_req = 1'b0;
        chk(lg_n == en, {rq, " bus transaction count"}, lg_n, en);
        for (int k = 0; k < en && k < lg_n; k++) begin
            chk(lg_cmd[k] == e_cmd[k] && lg_addr[k] == e_addr[k] &&
                (e_cmd[k] != 2'd3 || lg_dat[k] == e_dat[k]),
                {rq, " bus transaction"}, {lg_cmd[k], lg_addr[k], lg_dat[k]},
                {e_cmd[k], e_addr[k], (e_cmd[k] == 2'd3) ? e_dat[k] : lg_dat[k]});
        end
        if (!we) chk(got == e_rd, {rq, " read data"}, got, e_rd);
    endtask

    // One peer miss on the bus, checked against the model (R5..R8).
    task automatic snoop_op(input logic [1:0] cmd, input logic [7:0] addr);
        int idx = int'(addr[1:0]);
        bit match = (m_st[idx] != 0) && (m_tag[idx] == addr[7:2]);
        bit e_int = match && m_st[idx] == 2;
        string rq = (cmd == 2'd1) ? (e_int ? "R5" : "R8")
                                  : (e_int ? "R6" : (match ? "R7" : "R8"));
        @(negedge clk);
        snp_valid = 1'b1; snp_cmd = cmd; snp_addr = addr;
        #Q;
        chk(snp_intercept == e_int, {rq, " intercept"}, snp_intercept, e_int);
        if (e_int) begin
            chk(snp_data == m_dat[idx], {rq, " snoop data"}, snp_data, m_dat[idx]);
            mem[addr] = m_dat[idx];
        end
        if (match && cmd == 2'd2) m_st[idx] = 0;
        else if (e_int) m_st[idx] = 1;
        @(negedge clk);
        snp_valid = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd4242));
        lg_n = 0;
        for (int a = 0; a < 256; a++) mem[a] = 8'(a * 7 + 3);
        for (int i = 0; i < 4; i++) begin m_st[i] = 0; m_tag[i] = '0; m_dat[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #Q;
        chk(!bus_req && !cpu_ready, "R1 reset outputs", {bus_req, cpu_ready}, 0);
        for (int i = 0; i < 4; i++) snoop_op(2'd2, 8'(i));   // R1: nothing dirty

        cpu_op(0, 8'h05, 8'h00);   // R2 read miss
        cpu_op(0, 8'h05, 8'h00);   // R4 read hit in Shared
        cpu_op(1, 8'h05, 8'hA1);   // R3 upgrade from Shared
        cpu_op(1, 8'h05, 8'hA2);   // R4 write hit in Exclusive
        cpu_op(0, 8'h05, 8'h00);   // R4 read hit in Exclusive
        snoop_op(2'd1, 8'h09);     // R8 other tag
        snoop_op(2'd1, 8'h05);     // R5 flush, to Shared
        snoop_op(2'd1, 8'h05);     // R8 read snoop on Shared
        cpu_op(1, 8'h05, 8'hB3);   // R3 write miss from Shared
        cpu_op(0, 8'h09, 8'h00);   // R9 write-back then read miss
        cpu_op(1, 8'h0D, 8'hC4);   // R3 clean victim, write miss only
        cpu_op(1, 8'h11, 8'hD5);   // R9 write-back then write miss
        snoop_op(2'd2, 8'h11);     // R6 flush, to Invalid
        cpu_op(0, 8'h11, 8'h00);   // R2 refill sees flushed word
        snoop_op(2'd2, 8'h11);     // R7 Shared invalidated
        cpu_op(0, 8'h11, 8'h00);   // R2 misses again

        // R10: a hit is held off while a peer miss is on the bus.
        cpu_op(0, 8'h02, 8'h00);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 8'h02;
        snp_valid = 1'b1; snp_cmd = 2'd1; snp_addr = 8'h17;
        #Q;
        chk(cpu_ready == 1'b0, "R10 stall during snoop", cpu_ready, 0);
        @(negedge clk);
        snp_valid = 1'b0;
        #Q;
        chk(cpu_ready == 1'b1, "R10 released after snoop", cpu_ready, 1);
        @(negedge clk);
        cpu_req = 1'b0;

        for (int n = 0; n < 500; n++) begin
            logic [7:0] a = {6'($urandom % 3), 2'($urandom % 4)};
            int r = $urandom % 10;
            if (r < 4)      cpu_op(0, a, 8'h00);
            else if (r < 8) cpu_op(1, a, 8'($urandom));
            else            snoop_op((r == 8) ? 2'd1 : 2'd2, a);
        end
        finish_run();
    end
endmodule